// File: doc/BRIEF.md
# PWM Pulse Width Limiter

This block sits in the output path of a PWM channel, between the stage that sets and clears the waveform and the pin. It caps the high time of each pulse at a programmable number of clock cycles. A counter measures how long the current pulse has been high. A two-state gate passes the waveform until that count reaches the limit. After that the output is held low until the input rises again. Pulses shorter than the limit pass through unchanged, delayed by one clock.

The limit is written through a shadow register, and the write port is meant to be updated in the same step as the generator's compare values. The shadow value becomes the active limit only on a rising edge of the input. A pulse that is already running therefore always finishes under the limit it started with. A limit of zero keeps the output low. The shadow resets to zero, so the channel stays blocked until a limit has been written.

Top module: `pwm_ontime_clamp`

## Requirements
- R1: While reset is asserted, and after reset until a non-zero limit has taken effect, `pwm_o` is 0.
- R2: When `pwm_i` rises and the limit that takes effect is non-zero, `pwm_o` rises exactly one clock later.
- R3: A pulse of N cycles with N no greater than the active limit appears at `pwm_o` as exactly N high cycles, delayed by one clock.
- R4: A pulse longer than the active limit L gives exactly L high cycles at `pwm_o`, and the output then stays low until the next rising edge of `pwm_i`.
- R5: `pwm_o` is high only if `pwm_i` was high in the previous cycle.
- R6: A write (`lim_we_i`=1) stores `lim_data_i` in a shadow register. The shadow becomes the active limit only at a rising edge of `pwm_i`, and a write in the same cycle as that edge applies from the following pulse. A pulse in progress keeps its limit.
- R7: An active limit of 0 holds `pwm_o` at 0 for the whole pulse.
- R8: If `pwm_i` falls before the limit is reached, `pwm_o` falls one clock later, and the next pulse counts from the beginning again.
- R9: With a 20-cycle period, a 50% duty input and a limit of 6, `pwm_o` is high for 6 cycles in each period (30% duty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Raw PWM waveform from the generator |
| lim_we_i | input | 1 | Write strobe for the shadow limit |
| lim_data_i | input | CNT_W | New maximum on-time, in clock cycles |
| pwm_o | output | 1 | Clamped PWM waveform |

## Verification
The assertions assume that `pwm_i` is already synchronous to `clk_i`. Each rising edge of `pwm_i` is taken as one clean sampled transition, and the limit port may change in any cycle. The bench drives every input half a cycle away from the active clock edge, so each input is seen as a single sampled value. It writes limits at arbitrary moments, including in the middle of a pulse and in the same cycle as a rising edge. The pulse widths it uses fall below the limit, exactly at it, and above it, so that truncation, pass-through and the shadow hand-over are all exercised on the synchronous input.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic {
    GATE_BLOCK = 1'b0,
    GATE_PASS  = 1'b1
  } gate_state_e;
endpackage

// File: rtl/clamp_edge_det.sv
module clamp_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic pwm_q_o,
  output logic rise_o
);
  logic pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= pwm_i;
  end

  assign pwm_q_o = pwm_q;
  assign rise_o  = pwm_i & ~pwm_q;
endmodule

// File: rtl/clamp_limit_regs.sv
module clamp_limit_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             load_i,
  input  logic             pwm_i,
  input  logic             pwm_q_i,
  output logic [CNT_W-1:0] shd_o,
  output logic [CNT_W-1:0] act_o
);
  logic [CNT_W-1:0] shd_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (we_i)   shd_q <= data_i;
      if (load_i) act_q <= shd_q;
    end
  end

  assign shd_o = shd_q;
  assign act_o = act_q;

  // R6
  act_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_i && !pwm_q_i) |=> $stable(act_q));
endmodule

// File: rtl/clamp_gate.sv
module clamp_gate
  import clamp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             rise_i,
  input  logic [CNT_W-1:0] shd_i,
  input  logic [CNT_W-1:0] act_i,
  output logic             pass_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  gate_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= GATE_BLOCK;
      cnt_q   <= '0;
    end else if (rise_i) begin
      // new pulse: count restarts, limit taken from shadow
      state_q <= (shd_i != '0) ? GATE_PASS : GATE_BLOCK;
      cnt_q   <= ONE;
    end else if (!pwm_i) begin
      state_q <= GATE_BLOCK;
    end else if (state_q == GATE_PASS) begin
      if (cnt_q == act_i) state_q <= GATE_BLOCK;
      else                cnt_q   <= cnt_q + ONE;
    end
  end

  assign pass_o = (state_q == GATE_PASS);

  // R4
  cnt_in_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == GATE_PASS) |-> (cnt_q <= act_i));
endmodule

// File: rtl/pwm_ontime_clamp.sv
module pwm_ontime_clamp #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_data_i,
  output logic             pwm_o
);
  logic             pwm_q, rise, pass;
  logic [CNT_W-1:0] shd, act;

  clamp_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_i  (pwm_i),
    .pwm_q_o(pwm_q),
    .rise_o (rise)
  );

  clamp_limit_regs #(.CNT_W(CNT_W)) u_lim (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (lim_we_i),
    .data_i (lim_data_i),
    .load_i (rise),
    .pwm_i  (pwm_i),
    .pwm_q_i(pwm_q),
    .shd_o  (shd),
    .act_o  (act)
  );

  clamp_gate #(.CNT_W(CNT_W)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pwm_i (pwm_i),
    .rise_i(rise),
    .shd_i (shd),
    .act_i (act),
    .pass_o(pass)
  );

  assign pwm_o = pwm_q & pass;

  // R5
  out_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_o |-> $past(pwm_i));

  // R7
  zero_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act == '0) |-> !pwm_o);

  // R8
  pass_implies_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass |-> pwm_q);

  // R2
  rise_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise && shd != '0) |=> pwm_o);
endmodule

// File: tb/tb_pwm_ontime_clamp.sv
module tb_pwm_ontime_clamp;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pwm_in = 1'b0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         pwm_out;

  int    n_chk = 0, n_bad = 0;
  string phase = "R1";
  int    m_shadow = 0, m_active = 0, m_age = 0;
  bit    m_prev = 1'b0, m_exp = 1'b0;
  int    high_cnt = 0;
  bit    done = 1'b0;

  always #2 clk = ~clk;

  pwm_ontime_clamp #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm_in),
    .lim_we_i(we), .lim_data_i(wdata), .pwm_o(pwm_out)
  );

  // behavioural reference: pulse age versus limit captured at the rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_shadow = 0; m_active = 0; m_age = 0; m_prev = 1'b0; m_exp = 1'b0;
    end else begin
      if (pwm_in && !m_prev) begin
        m_active = m_shadow;
        m_age = 1;
      end else if (pwm_in) begin
        m_age++;
      end
      m_exp = pwm_in && (m_age <= m_active);
      if (we) m_shadow = int'(wdata);
      m_prev = pwm_in;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (pwm_out !== m_exp) begin
        n_bad++;
        $display("FAIL %s: pwm_o=%0b expected %0b at %0t", phase, pwm_out, m_exp, $time);
      end
      if (pwm_out === 1'b1) high_cnt++;
    end
  end

  task automatic step(input bit p, input bit w, input int d);
    pwm_in = p; we = w; wdata = W'(d);
    @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    for (int i = 0; i < hi; i++) step(1'b1, 1'b0, 0);
    for (int i = 0; i < lo; i++) step(1'b0, 1'b0, 0);
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check_val("R1 reset", int'(pwm_out), 0);
    rst_n = 1'b1;
    phase = "R1,R7";
    pulse(4, 3); pulse(2, 2);
    phase = "R2,R3,R5";
    step(1'b0, 1'b1, 5); step(1'b0, 1'b0, 0);
    pulse(3, 3); pulse(5, 2); pulse(1, 1);
    phase = "R4";
    pulse(9, 4); pulse(6, 1);
    phase = "R6";
    step(1'b1, 1'b0, 0); step(1'b1, 1'b0, 0);
    step(1'b1, 1'b1, 2);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 0); step(1'b0, 1'b0, 0);
    high_cnt = 0;
    pulse(7, 3);
    check_val("R6 new limit", high_cnt, 2);
    step(1'b1, 1'b1, 8);
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 0);
    step(1'b0, 1'b0, 0);
    pulse(10, 2);
    phase = "R8";
    pulse(3, 1); pulse(1, 1); pulse(8, 3); pulse(12, 2);
    phase = "R7";
    step(1'b0, 1'b1, 0); step(1'b0, 1'b0, 0);
    high_cnt = 0;
    pulse(6, 2); pulse(15, 2);
    check_val("R7 zero limit", high_cnt, 0);
    phase = "R9";
    step(1'b0, 1'b1, 6);
    for (int i = 0; i < 10; i++) step(1'b0, 1'b0, 0);
    for (int k = 0; k < 4; k++) begin
      high_cnt = 0;
      pulse(10, 10);
      check_val("R9 duty", high_cnt, 6);
    end
    phase = "R3,R4";
    step(1'b0, 1'b1, 1); step(1'b0, 1'b0, 0);
    pulse(1, 1); pulse(4, 2);
    step(1'b0, 1'b1, 65535); step(1'b0, 1'b0, 0);
    high_cnt = 0;
    pulse(40, 3);
    check_val("R3 long limit", high_cnt, 40);
    phase = "R1";
    rst_n = 1'b0;
    step(1'b1, 1'b0, 0);
    check_val("R1 reset again", int'(pwm_out), 0);
    rst_n = 1'b1;
    pulse(5, 2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule